// File: doc/BRIEF.md
# Pipelined Burst Memory with Lane Writes

This block is a clocked single-port memory whose 36-bit word is split into four byte lanes. Each lane has eight data bits and one parity bit. An access begins when one of two address strobes is sampled low while the chip is selected. A processor-side strobe always starts a read and ignores the write controls on that edge. A controller-side strobe only counts when the processor strobe is high on the same edge, and it honours the write controls at once.

After an access has started, further cycles come from an internal burst counter. An advance input moves the counter to the next location in either a linear (wrapping add) or an exclusive-or ordering. Read data passes through one output register. A sleep input freezes the block completely.

The depth of the memory is set by an address-width parameter. The burst length is set by a counter-width parameter.

Top module: `burst_sram`

## Requirements
- R1: A processor strobe (`proc_strb_n` low) sampled on a rising edge with the chip selected (`ce_n` low and `ce_p` high) loads `addr_i` as the burst base and reads that word. The word appears on `rdata_o` with `rvalid_o` high after that edge, provided `oe_n` was low on that edge.
- R2: On an edge that starts a cycle from the processor strobe, `gw_n`, `bwe_n` and `lane_we_n` have no effect and the memory is not written. On the following edges of the same burst these inputs are honoured, and a write lands on the burst's current address.
- R3: A controller strobe (`ctrl_strb_n` low) starts a cycle only when `proc_strb_n` is high on the same edge. Its write controls are honoured on that edge, at address `addr_i`.
- R4: When both strobes are low on one edge, the edge behaves as a processor-strobe start: it is a read, and writes are ignored.
- R5: `gw_n` low writes all four lanes of the word, whatever `bwe_n` and `lane_we_n` are.
- R6: With `gw_n` high and `bwe_n` low, each lane `i` whose `lane_we_n[i]` is low is written. Lane `i` holds data bits `[8i+7:8i]` and parity bit `32+i`. Other lanes keep their contents. With `bwe_n` high and `gw_n` high, nothing is written and the cycle is a read.
- R7: With `burst_order` 0 at the start edge, each later edge with `adv_n` low reads (or writes) the next address. The next address adds one to the low two address bits, modulo 4; the upper bits stay fixed. After four steps the burst wraps to the start address.
- R8: With `burst_order` 1 at the start edge, step `k` of the burst uses the low two bits of the start address XOR `k`.
- R9: With both strobes high, `adv_n` high and no write enabled, the burst address and the output register hold (a wait state).
- R10: While `sleep_i` is high, no access takes place. Stored words, the burst state, the output register and `rvalid_o` are all kept, and the burst resumes afterwards.
- R11: `rvalid_o` is high only if the most recent access was a read and `oe_n` was low on the last edge outside sleep. `rdata_o` is zero whenever `rvalid_o` is low.
- R12: A strobe sampled with the chip deselected performs no access and ends the current burst. Later advance or write inputs have no effect until a new start.
- R13: Synchronous active-high `rst` clears the output register, `rvalid_o` and the burst state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| sleep_i | input | 1 | Power-down hold, active high |
| ce_n | input | 1 | Chip select, active low |
| ce_p | input | 1 | Chip select, active high |
| proc_strb_n | input | 1 | Processor-side address strobe, active low |
| ctrl_strb_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write of all lanes, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| lane_we_n | input | 4 | Per-lane write enables, active low |
| oe_n | input | 1 | Output enable, active low, sampled on the clock |
| burst_order | input | 1 | Burst ordering: 0 linear, 1 XOR |
| addr_i | input | 10 | External word address |
| wdata_i | input | 36 | Write data |
| rdata_o | output | 36 | Registered read data |
| rvalid_o | output | 1 | Read data valid |

## Verification
The hardest situation to reach is a write that arrives on the edge after a processor strobe, first during a wait state and then together with an advance. It must land on the burst address and not on whatever is on `addr_i`. The stimulus opens a burst with the processor strobe and global write both low, which must be ignored. It then writes through a wait edge and an advance edge, and reads the words back. A second hard case is a sleep window placed in the middle of a burst, with every strobe and write line active. The stimulus checks that the burst then resumes at the right step, and that the word on the bus during sleep was left untouched.

// File: rtl/bsram_pkg.sv
`timescale 1ns/1ps
package bsram_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    typedef enum logic {
        ORDER_LINEAR = 1'b0,
        ORDER_XOR    = 1'b1
    } order_e;

    typedef struct packed {
        op_e  op;
        logic load;
        logic step;
        logic drop;
    } seq_t;

endpackage

// File: rtl/bsram_ctrl.sv
`timescale 1ns/1ps
module bsram_ctrl
    import bsram_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             sleep_i,
    input  logic             chip_sel,
    input  logic             proc_strb_n,
    input  logic             ctrl_strb_n,
    input  logic             adv_n,
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] lane_we_n,
    input  logic             busy,
    output seq_t             seq,
    output logic [LANES-1:0] lane_wr
);

    logic             any_strb;
    logic             start_p;
    logic             start_c;
    logic             cont;
    logic [LANES-1:0] req_mask;

    always_comb begin
        any_strb = !proc_strb_n || !ctrl_strb_n;
        start_p  = !proc_strb_n && chip_sel;
        start_c  = proc_strb_n && !ctrl_strb_n && chip_sel;
        cont     = busy && !any_strb;
        if (!gw_n) begin
            req_mask = '1;
        end else if (!bwe_n) begin
            req_mask = ~lane_we_n;
        end else begin
            req_mask = '0;
        end

        seq.op   = OP_NONE;
        seq.load = 1'b0;
        seq.step = 1'b0;
        seq.drop = 1'b0;
        lane_wr  = '0;

        if (!sleep_i) begin
            if (start_p) begin
                seq.op   = OP_READ;
                seq.load = 1'b1;
            end else if (start_c) begin
                seq.load = 1'b1;
                lane_wr  = req_mask;
                seq.op   = (|req_mask) ? OP_WRITE : OP_READ;
            end else if (any_strb) begin
                seq.drop = 1'b1;
            end else if (cont) begin
                seq.step = !adv_n;
                lane_wr  = req_mask;
                if (|req_mask) begin
                    seq.op = OP_WRITE;
                end else if (!adv_n) begin
                    seq.op = OP_READ;
                end
            end
        end
    end

endmodule

// File: rtl/bsram_addr.sv
`timescale 1ns/1ps
module bsram_addr
    import bsram_pkg::*;
#(
    parameter int ADDR_W  = 10,
    parameter int BURST_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  seq_t              seq,
    input  logic [ADDR_W-1:0] addr_i,
    input  order_e            order_i,
    output logic              busy,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [ADDR_W-1:0] acc_addr
);

    logic [ADDR_W-1:0]  base_q;
    logic [BURST_W-1:0] cnt_q;
    logic [BURST_W-1:0] cnt_nx;
    order_e             mode_q;
    logic               busy_q;
    logic [ADDR_W-1:0]  nxt_addr;

    function automatic logic [BURST_W-1:0] step_ofs(
        input logic [BURST_W-1:0] b,
        input logic [BURST_W-1:0] k,
        input order_e             m
    );
        return (m == ORDER_XOR) ? (b ^ k) : (b + k);
    endfunction

    assign cnt_nx   = cnt_q + 1'b1;
    assign cur_addr = {base_q[ADDR_W-1:BURST_W],
                       step_ofs(base_q[BURST_W-1:0], cnt_q, mode_q)};
    assign nxt_addr = {base_q[ADDR_W-1:BURST_W],
                       step_ofs(base_q[BURST_W-1:0], cnt_nx, mode_q)};
    assign acc_addr = seq.load ? addr_i : (seq.step ? nxt_addr : cur_addr);
    assign busy     = busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            cnt_q  <= '0;
            mode_q <= ORDER_LINEAR;
            busy_q <= 1'b0;
        end else if (seq.load) begin
            base_q <= addr_i;
            cnt_q  <= '0;
            mode_q <= order_i;
            busy_q <= 1'b1;
        end else begin
            if (seq.step) begin
                cnt_q <= cnt_nx;
            end
            if (seq.drop) begin
                busy_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/bsram_array.sv
`timescale 1ns/1ps
module bsram_array
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANES  = 4,
    parameter int LANE_D = 8,
    parameter int WORD_W = LANES * (LANE_D + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  op_e               op,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [LANES-1:0]  lane_wr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata_q
);

    localparam int DEPTH  = 1 << ADDR_W;
    localparam int DATA_W = LANES * LANE_D;

    logic [WORD_W-1:0] mem [DEPTH];
    logic [WORD_W-1:0] bit_en;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign bit_en[g*LANE_D +: LANE_D] = {LANE_D{lane_wr[g]}};
        assign bit_en[DATA_W + g]         = lane_wr[g];
    end

    always_ff @(posedge clk) begin
        if (op == OP_WRITE) begin
            mem[acc_addr] <= (mem[acc_addr] & ~bit_en) | (wdata & bit_en);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (op == OP_READ) begin
            rdata_q <= mem[acc_addr];
        end
    end

endmodule

// File: rtl/burst_sram.sv
`timescale 1ns/1ps
module burst_sram
    import bsram_pkg::*;
#(
    parameter int  ADDR_W  = 10,
    parameter int  BURST_W = 2,
    parameter int  LANES   = 4,
    parameter int  LANE_D  = 8,
    localparam int WORD_W  = LANES * (LANE_D + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sleep_i,
    input  logic              ce_n,
    input  logic              ce_p,
    input  logic              proc_strb_n,
    input  logic              ctrl_strb_n,
    input  logic              adv_n,
    input  logic              gw_n,
    input  logic              bwe_n,
    input  logic [LANES-1:0]  lane_we_n,
    input  logic              oe_n,
    input  logic              burst_order,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [WORD_W-1:0] rdata_o,
    output logic              rvalid_o
);

    seq_t              seq;
    logic [LANES-1:0]  lane_wr;
    logic              busy;
    logic [ADDR_W-1:0] cur_addr;
    logic [ADDR_W-1:0] acc_addr;
    logic [WORD_W-1:0] rdata_q;
    logic              rd_last;
    logic              oe_q;

    bsram_ctrl #(.LANES(LANES)) ctrl_i (
        .sleep_i     (sleep_i),
        .chip_sel    (!ce_n && ce_p),
        .proc_strb_n (proc_strb_n),
        .ctrl_strb_n (ctrl_strb_n),
        .adv_n       (adv_n),
        .gw_n        (gw_n),
        .bwe_n       (bwe_n),
        .lane_we_n   (lane_we_n),
        .busy        (busy),
        .seq         (seq),
        .lane_wr     (lane_wr)
    );

    bsram_addr #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) addr_i_gen (
        .clk      (clk),
        .rst      (rst),
        .seq      (seq),
        .addr_i   (addr_i),
        .order_i  (order_e'(burst_order)),
        .busy     (busy),
        .cur_addr (cur_addr),
        .acc_addr (acc_addr)
    );

    bsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_D(LANE_D),
                  .WORD_W(WORD_W)) array_i (
        .clk      (clk),
        .rst      (rst),
        .op       (seq.op),
        .acc_addr (acc_addr),
        .lane_wr  (lane_wr),
        .wdata    (wdata_i),
        .rdata_q  (rdata_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_last <= 1'b0;
            oe_q    <= 1'b1;
        end else if (!sleep_i) begin
            oe_q <= oe_n;
            if (seq.op == OP_WRITE) begin
                rd_last <= 1'b0;
            end else if (seq.op == OP_READ) begin
                rd_last <= 1'b1;
            end
        end
    end

    assign rvalid_o = rd_last && !oe_q;
    assign rdata_o  = rvalid_o ? rdata_q : '0;

endmodule

// File: rtl/bsram_chk.sv
`timescale 1ns/1ps
module bsram_chk #(
    parameter int ADDR_W = 10,
    parameter int LANES  = 4,
    parameter int WORD_W = 36
) (
    input logic              clk,
    input logic              rst,
    input logic              sleep_i,
    input logic              ce_n,
    input logic              ce_p,
    input logic              proc_strb_n,
    input logic              ctrl_strb_n,
    input logic              adv_n,
    input logic              gw_n,
    input logic              bwe_n,
    input logic [LANES-1:0]  lane_we_n,
    input logic              oe_n,
    input logic [ADDR_W-1:0] addr_i,
    input logic [WORD_W-1:0] rdata_o,
    input logic              rvalid_o,
    input logic [ADDR_W-1:0] cur_addr,
    input logic [WORD_W-1:0] rdata_q
);

    logic p_start;
    logic idle_edge;

    assign p_start   = !sleep_i && !proc_strb_n && !ce_n && ce_p;
    assign idle_edge = !sleep_i && proc_strb_n && ctrl_strb_n && adv_n
                       && gw_n && (bwe_n || (&lane_we_n));

    // R13
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!rvalid_o && rdata_o == '0));

    // R1
    start_load_chk: assert property (@(posedge clk) disable iff (rst)
        p_start |=> cur_addr == $past(addr_i));

    // R2
    start_is_read_chk: assert property (@(posedge clk) disable iff (rst)
        p_start |=> rvalid_o == !$past(oe_n));

    // R9
    wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
        idle_edge |=> ($stable(rdata_q) && $stable(cur_addr)));

    // R10
    sleep_hold_chk: assert property (@(posedge clk) disable iff (rst)
        sleep_i |=> ($stable(rdata_q) && $stable(cur_addr) && $stable(rvalid_o)));

    // R11
    oe_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (oe_n && !sleep_i) |=> !rvalid_o);

endmodule

bind burst_sram bsram_chk #(.ADDR_W(ADDR_W), .LANES(LANES), .WORD_W(WORD_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .sleep_i     (sleep_i),
    .ce_n        (ce_n),
    .ce_p        (ce_p),
    .proc_strb_n (proc_strb_n),
    .ctrl_strb_n (ctrl_strb_n),
    .adv_n       (adv_n),
    .gw_n        (gw_n),
    .bwe_n       (bwe_n),
    .lane_we_n   (lane_we_n),
    .oe_n        (oe_n),
    .addr_i      (addr_i),
    .rdata_o     (rdata_o),
    .rvalid_o    (rvalid_o),
    .cur_addr    (cur_addr),
    .rdata_q     (rdata_q)
);

// File: tb/burst_sram_tb_top.sv
`timescale 1ns/1ps
module burst_sram_tb_top;

    localparam int K_RD = 0, K_WR = 1, K_HOLD = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sleep_i, ce_n, ce_p, proc_strb_n, ctrl_strb_n, adv_n;
    logic        gw_n, bwe_n, oe_n, burst_order;
    logic [3:0]  lane_we_n;
    logic [9:0]  addr_i;
    logic [35:0] wdata_i;
    logic [35:0] rdata_o;
    logic        rvalid_o;

    int checks = 0;
    int fails  = 0;
    int cnt    = 0;

    typedef struct {
        int          stamp;
        logic        ev;
        logic [35:0] ed;
        string       req;
    } exp_t;
    exp_t q[$];

    logic [35:0] sh [1024];
    logic        m_rd = 1'b0;
    logic        m_oe = 1'b1;
    logic [35:0] m_q  = '0;

    burst_sram dut_i (
        .clk(clk), .rst(rst), .sleep_i(sleep_i), .ce_n(ce_n), .ce_p(ce_p),
        .proc_strb_n(proc_strb_n), .ctrl_strb_n(ctrl_strb_n), .adv_n(adv_n),
        .gw_n(gw_n), .bwe_n(bwe_n), .lane_we_n(lane_we_n), .oe_n(oe_n),
        .burst_order(burst_order), .addr_i(addr_i), .wdata_i(wdata_i),
        .rdata_o(rdata_o), .rvalid_o(rvalid_o)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cnt <= cnt + 1;

    function automatic logic [35:0] wmask(logic g, logic b, logic [3:0] l);
        logic [3:0]  m;
        logic [35:0] r;
        m = !g ? 4'hF : (!b ? ~l : 4'h0);
        r = '0;
        for (int i = 0; i < 4; i++) begin
            r[i*8 +: 8] = {8{m[i]}};
            r[32+i]     = m[i];
        end
        return r;
    endfunction

    function automatic logic [9:0] lin_a(logic [9:0] a, int k);
        logic [1:0] lo;
        lo = a[1:0] + 2'(k);
        return {a[9:2], lo};
    endfunction

    function automatic logic [9:0] xor_a(logic [9:0] a, int k);
        return {a[9:2], a[1:0] ^ 2'(k)};
    endfunction

    task automatic defaults();
        sleep_i = 0; ce_n = 0; ce_p = 1; proc_strb_n = 1; ctrl_strb_n = 1;
        adv_n = 1; gw_n = 1; bwe_n = 1; lane_we_n = 4'hF; oe_n = 0;
        burst_order = 0; addr_i = '0; wdata_i = '0;
    endtask

    // driver: updates the model from the requirements, then queues the result
    task automatic tick(int kind, logic [9:0] a, string req);
        exp_t it;
        logic [35:0] mk;
        if (!sleep_i) begin
            m_oe = oe_n;
            if (kind == K_RD) begin
                m_q  = sh[a];
                m_rd = 1'b1;
            end else if (kind == K_WR) begin
                mk    = wmask(gw_n, bwe_n, lane_we_n);
                sh[a] = (sh[a] & ~mk) | (wdata_i & mk);
                m_rd  = 1'b0;
            end
        end
        @(posedge clk);
        #1;
        it.stamp = cnt;
        it.ev    = m_rd && !m_oe;
        it.ed    = it.ev ? m_q : 36'h0;
        it.req   = req;
        q.push_back(it);
    endtask

    task automatic wr_ctrl(logic [9:0] a, logic [35:0] d, string req);
        ctrl_strb_n = 0; gw_n = 0; addr_i = a; wdata_i = d;
        tick(K_WR, a, req);
        defaults();
    endtask

    task automatic rd_proc(logic [9:0] a, logic ord, string req);
        proc_strb_n = 0; addr_i = a; burst_order = ord;
        tick(K_RD, a, req);
        defaults();
    endtask

    // monitor: pops and compares as results appear
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].stamp == cnt) begin
            exp_t it;
            it = q.pop_front();
            checks++;
            if (rdata_o !== it.ed || rvalid_o !== it.ev) begin
                fails++;
                $display("FAIL %s: rdata=%h rvalid=%b expected rdata=%h rvalid=%b",
                         it.req, rdata_o, rvalid_o, it.ed, it.ev);
            end
        end
    end

    initial begin
        #1000000;
        checks++;
        fails++;
        $display("FAIL watchdog: run hung, actual=timeout expected=completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        defaults();
        rst = 1;
        repeat (3) @(posedge clk);
        #1;
        rst = 0;
        @(negedge clk);
        checks++;
        if (rdata_o !== 36'h0 || rvalid_o !== 1'b0) begin
            fails++;
            $display("FAIL R13: rdata=%h rvalid=%b expected 0 0", rdata_o, rvalid_o);
        end
        @(posedge clk);
        #1;

        // R3 R5: controller strobe writes on its own edge; R1 read back
        wr_ctrl(10'h010, 36'h9_1234_5678, "R3");
        rd_proc(10'h010, 0, "R1");

        // R2: write controls ignored on processor strobe edge
        wr_ctrl(10'h020, 36'hA_AAAA_0001, "R2");
        proc_strb_n = 0; gw_n = 0; addr_i = 10'h020; wdata_i = 36'h5_5555_5555;
        tick(K_RD, 10'h020, "R2");
        defaults();
        rd_proc(10'h020, 0, "R2");

        // R6: per-lane writes, lanes 0 and 2
        wr_ctrl(10'h030, 36'h0_0000_0000, "R6");
        ctrl_strb_n = 0; bwe_n = 0; lane_we_n = 4'b1010;
        addr_i = 10'h030; wdata_i = 36'hF_FFFF_FFFF;
        tick(K_WR, 10'h030, "R6");
        defaults();
        rd_proc(10'h030, 0, "R6");
        // R6: lane enables without byte-write enable do nothing
        ctrl_strb_n = 0; lane_we_n = 4'h0; addr_i = 10'h030; wdata_i = 36'h3_1111_2222;
        tick(K_RD, 10'h030, "R6");
        defaults();
        // R5: global write overrides lane selection
        ctrl_strb_n = 0; gw_n = 0; bwe_n = 0; lane_we_n = 4'b1110;
        addr_i = 10'h030; wdata_i = 36'h6_CAFE_BABE;
        tick(K_WR, 10'h030, "R5");
        defaults();
        rd_proc(10'h030, 0, "R5");

        // R4: both strobes low behaves as processor start
        proc_strb_n = 0; ctrl_strb_n = 0; gw_n = 0; addr_i = 10'h030;
        wdata_i = 36'h0_0BAD_0BAD;
        tick(K_RD, 10'h030, "R4");
        defaults();
        rd_proc(10'h030, 0, "R4");

        // R7 R9: linear burst with a wait state
        for (int i = 0; i < 4; i++) wr_ctrl(10'h040 + 10'(i), 36'h1_0000_0040 + 36'(i * 17), "R7");
        rd_proc(10'h042, 0, "R7");
        for (int k = 1; k <= 4; k++) begin
            adv_n = 0;
            tick(K_RD, lin_a(10'h042, k), "R7");
            defaults();
            if (k == 2) begin
                tick(K_HOLD, 10'h0, "R9");
                tick(K_HOLD, 10'h0, "R9");
            end
        end

        // R8: XOR burst
        rd_proc(10'h041, 1, "R8");
        for (int k = 1; k <= 3; k++) begin
            adv_n = 0;
            tick(K_RD, xor_a(10'h041, k), "R8");
            defaults();
        end

        // R2 R7: writes on edges after a processor start follow the burst address
        for (int i = 0; i < 4; i++) wr_ctrl(10'h050 + 10'(i), 36'h2_0000_0050 + 36'(i), "R2");
        proc_strb_n = 0; gw_n = 0; addr_i = 10'h050; wdata_i = 36'h7_7777_7777;
        tick(K_RD, 10'h050, "R2");
        defaults();
        gw_n = 0; addr_i = 10'h3FF; wdata_i = 36'h8_D0D0_D0D0;
        tick(K_WR, 10'h050, "R2");
        defaults();
        gw_n = 0; adv_n = 0; addr_i = 10'h3FF; wdata_i = 36'h8_D1D1_D1D1;
        tick(K_WR, 10'h051, "R7");
        defaults();
        rd_proc(10'h050, 0, "R2");
        adv_n = 0;
        tick(K_RD, 10'h051, "R7");
        defaults();

        // R10: sleep mid-burst with all controls active, then resume
        sleep_i = 1; proc_strb_n = 0; gw_n = 0; adv_n = 0; oe_n = 1;
        addr_i = 10'h010; wdata_i = 36'hE_EEEE_EEEE;
        tick(K_HOLD, 10'h0, "R10");
        tick(K_HOLD, 10'h0, "R10");
        defaults();
        adv_n = 0;
        tick(K_RD, 10'h052, "R10");
        defaults();
        rd_proc(10'h010, 0, "R10");

        // R11: output enable high suppresses valid, recovers on hold edge
        oe_n = 1;
        rd_proc(10'h010, 0, "R11");
        oe_n = 1;
        rd_proc(10'h020, 0, "R11");
        tick(K_HOLD, 10'h0, "R11");

        // R12: deselected strobe ends the burst
        rd_proc(10'h040, 0, "R12");
        ce_n = 1; proc_strb_n = 0; addr_i = 10'h020;
        tick(K_HOLD, 10'h0, "R12");
        defaults();
        adv_n = 0;
        tick(K_HOLD, 10'h0, "R12");
        defaults();
        gw_n = 0; wdata_i = 36'h0_DEAD_BEEF;
        tick(K_HOLD, 10'h0, "R12");
        defaults();
        rd_proc(10'h040, 0, "R12");
        ce_p = 0; ctrl_strb_n = 0; gw_n = 0; addr_i = 10'h041; wdata_i = 36'h0;
        tick(K_HOLD, 10'h0, "R12");
        defaults();
        rd_proc(10'h041, 0, "R12");

        repeat (2) @(posedge clk);
        @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule